// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

This block sits beside a UART receiver and tells the interrupt unit when incoming data has stopped while bytes are still waiting in the receive FIFO. Software can then drain a short message whose length never reached a fill threshold. Idle time is measured in character times, not clock cycles. A prescaler divides the bit-rate tick by eight, and each whole group of eight ticks is one idle unit. A saturating counter accumulates these units.

Counting starts only after a byte has been received and only while the FIFO holds data. Every new byte restarts both the prescaler and the idle counter. Once the idle count exceeds the programmed 7-bit threshold, the timeout level rises. It stays high until the FIFO has been emptied or the function is disabled.

Top module: `uart_rx_idle_timeout`

## Requirements
- R1: While `rto_en_i` is low, `timeout_o` is low one cycle later and stays low, whatever the other inputs do.
- R2: One idle unit is exactly 8 accepted `bit_tick_i` pulses. Seven ticks after a byte never complete a unit.
- R3: `timeout_o` rises on the clock edge after the edge that completes idle unit `thresh_i + 1`, counted from the last received byte.
- R4: No idle time is counted until a byte has been received since the FIFO was last empty. A non-empty FIFO with no byte since then never raises a timeout.
- R5: A `byte_rx_i` pulse clears the prescaler phase and the idle count. Ticks seen before the byte do not count toward the next timeout.
- R6: Once high, `timeout_o` stays high while the FIFO is non-empty and the block is enabled. A new byte does not clear it.
- R7: A low `fifo_nonempty_i` drops `timeout_o` on the next edge and holds the idle count at zero.
- R8: The idle counter saturates at 255 instead of wrapping. With threshold 127, the timeout fires after 128 units and stays high through any longer idle time.
- R9: With a threshold of 0, the timeout rises after the first whole idle unit that follows the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit period on the line |
| byte_rx_i | input | 1 | One-cycle pulse when a byte is written to the receive FIFO |
| fifo_nonempty_i | input | 1 | High while the receive FIFO holds at least one byte |
| rto_en_i | input | 1 | Timeout function enable |
| thresh_i | input | 7 | Idle threshold in character units (0 to 127) |
| timeout_o | output | 1 | Timeout level for the interrupt unit |

## Verification
The assertions assume a few things about the inputs:
- `byte_rx_i` never pulses while the FIFO is marked empty in the same cycle without the flag following.
- Ticks and byte strobes last one clock each.
- The threshold is held steady while a count is in progress.

The random stimulus follows these rules. It draws ticks and bytes as single-cycle pulses, and it changes the threshold only while the FIFO is empty. It lowers the FIFO flag only in short bursts. The directed cases reach the threshold edges at 0 and 127, saturation, and restart by a late byte.

// File: rtl/uart_rto_pkg.sv
package uart_rto_pkg;
  localparam int unsigned RTO_TH_W       = 7;
  localparam int unsigned RTO_TICKS_UNIT = 8;

  function automatic logic [RTO_TH_W:0] sat_inc(input logic [RTO_TH_W:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/uart_rto_prescaler.sv
module uart_rto_prescaler #(
  parameter int unsigned TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic unit_o
);
  localparam int unsigned PW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

  logic [PW-1:0] phase_q;

  assign unit_o = tick_i & ~clr_i & (phase_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 phase_q <= '0;
    else if (clr_i || unit_o)    phase_q <= '0;
    else if (tick_i)             phase_q <= phase_q + 1'b1;
  end

  assert_clear_restarts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (phase_q == '0));

  assert_unit_needs_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q) || (phase_q == '0));
endmodule

// File: rtl/uart_rto_idle_cnt.sv
module uart_rto_idle_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&cnt_q) && !clr_i) |=> (&cnt_q));

  assert_cleared_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/uart_rx_idle_timeout.sv
module uart_rx_idle_timeout
  import uart_rto_pkg::*;
#(
  parameter int unsigned TH_W  = RTO_TH_W,
  parameter int unsigned TICKS = RTO_TICKS_UNIT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_tick_i,
  input  logic            byte_rx_i,
  input  logic            fifo_nonempty_i,
  input  logic            rto_en_i,
  input  logic [TH_W-1:0] thresh_i,
  output logic            timeout_o
);
  localparam int unsigned CW = TH_W + 1;

  logic          armed_q, active, clr, unit;
  logic [CW-1:0] idle_cnt;
  logic          to_q;

  // counting runs only after a byte has arrived and while data is pending
  assign active = rto_en_i & fifo_nonempty_i & armed_q;
  assign clr    = byte_rx_i | ~active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= byte_rx_i | (armed_q & fifo_nonempty_i);
  end

  uart_rto_prescaler #(.TICKS(TICKS)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .tick_i(bit_tick_i),
    .unit_o(unit)
  );

  uart_rto_idle_cnt #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (unit),
    .cnt_o (idle_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           to_q <= 1'b0;
    else if (!rto_en_i || !fifo_nonempty_i) to_q <= 1'b0;
    else if (armed_q && (idle_cnt > {1'b0, thresh_i})) to_q <= 1'b1;
  end

  assign timeout_o = to_q;

  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rto_en_i |=> !timeout_o);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && rto_en_i && fifo_nonempty_i) |=> timeout_o);

  assert_drain_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_nonempty_i |=> (!timeout_o && idle_cnt == '0));

  assert_not_before_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !byte_rx_i) |=> (idle_cnt == '0));
endmodule

// File: tb/sim_uart_rx_idle_timeout.sv
`timescale 1ns/1ps
module sim_uart_rx_idle_timeout;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_tick_i = 1'b0, byte_rx_i = 1'b0, fifo_nonempty_i = 1'b0, rto_en_i = 1'b0;
  logic [6:0] thresh_i = '0;
  logic       timeout_o;

  int n_chk = 0, n_fail = 0;
  bit m_armed = 0, m_to = 0;
  int m_pre = 0, m_cnt = 0;

  always #4 clk_i = ~clk_i;

  uart_rx_idle_timeout u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_tick_i(bit_tick_i), .byte_rx_i(byte_rx_i),
    .fifo_nonempty_i(fifo_nonempty_i), .rto_en_i(rto_en_i), .thresh_i(thresh_i),
    .timeout_o(timeout_o)
  );

  function automatic void model_step(bit tk, bit by, bit ne, bit en, int thr);
    bit act = en && ne && m_armed;
    bit nto = (!en || !ne) ? 1'b0 : (m_to || (m_armed && m_cnt > thr));
    if (by || !act) begin m_pre = 0; m_cnt = 0; end
    else if (tk) begin
      if (m_pre == 7) begin m_pre = 0; if (m_cnt < 255) m_cnt++; end
      else m_pre++;
    end
    m_armed = by || (m_armed && ne);
    m_to = nto;
  endfunction

  task automatic check(bit act, bit exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: timeout_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle at negedge, advance model, compare at next negedge
  task automatic cyc(bit tk, bit by, bit ne, string tag);
    bit_tick_i = tk; byte_rx_i = by; fifo_nonempty_i = ne;
    model_step(tk, by, ne, rto_en_i, int'(thresh_i));
    @(negedge clk_i);
    check(timeout_o, m_to, tag);
  endtask

  task automatic idle_ticks(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 1, tag);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++; n_chk++;
    $display("FAIL watchdog: timeout_o=%0b expected run end", timeout_o);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check(timeout_o, 1'b0, "reset");
    rst_ni = 1'b1;
    rto_en_i = 1'b1;
    @(negedge clk_i);

    // R9 / R2: threshold 0, seven ticks do not complete a unit
    thresh_i = 7'd0;
    cyc(0, 1, 1, "R9");
    idle_ticks(7, "R2");
    check(timeout_o, 1'b0, "R2");
    cyc(1, 0, 1, "R9");     // unit 1 completes
    cyc(0, 0, 1, "R9");     // flag registers
    check(timeout_o, 1'b1, "R9");

    // R6: late byte does not clear; R7: drain clears
    cyc(0, 1, 1, "R6");
    check(timeout_o, 1'b1, "R6");
    cyc(0, 0, 0, "R7");
    check(timeout_o, 1'b0, "R7");

    // R4: non-empty without a fresh byte never counts
    repeat (10) cyc(0, 0, 0, "R4");
    idle_ticks(100, "R4");
    check(timeout_o, 1'b0, "R4");

    // R5: ticks before a byte are discarded (threshold 1 -> 16 ticks)
    cyc(0, 0, 0, "R5");
    thresh_i = 7'd1;
    cyc(0, 1, 1, "R5");
    idle_ticks(15, "R5");
    cyc(0, 1, 1, "R5");
    idle_ticks(15, "R5");
    cyc(0, 0, 1, "R5");
    check(timeout_o, 1'b0, "R5");
    cyc(1, 0, 1, "R3");
    cyc(0, 0, 1, "R3");
    check(timeout_o, 1'b1, "R3");

    // R1: disabled never raises
    cyc(0, 0, 0, "R1");
    rto_en_i = 1'b0;
    thresh_i = 7'd0;
    cyc(0, 1, 1, "R1");
    idle_ticks(64, "R1");
    check(timeout_o, 1'b0, "R1");
    rto_en_i = 1'b1;
    cyc(0, 0, 0, "R1");

    // R8: threshold 127, fires after 128 units, holds through saturation
    thresh_i = 7'd127;
    cyc(0, 1, 1, "R8");
    idle_ticks(128 * 8 - 1, "R8");
    check(timeout_o, 1'b0, "R8");
    cyc(1, 0, 1, "R8");
    cyc(0, 0, 1, "R8");
    check(timeout_o, 1'b1, "R8");
    idle_ticks(140 * 8, "R8");
    check(timeout_o, 1'b1, "R8");
    cyc(0, 0, 0, "R7");

    // random phase, threshold changes only while empty
    for (int blk = 0; blk < 60; blk++) begin
      cyc(0, 0, 0, "R7");
      thresh_i = 7'($urandom_range(0, 4));
      rto_en_i = ($urandom_range(0, 9) != 0);
      for (int c = 0; c < 400; c++) begin
        bit tk = ($urandom_range(0, 1) == 1);
        bit by = ($urandom_range(0, 60) == 0);
        bit ne = by || ($urandom_range(0, 150) != 0);
        cyc(tk, by, ne, "R3");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule